// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory Controller

This block keeps the coherence directory for a group of memory blocks in a bus-less shared-memory multiprocessor. Each directory entry records up to `NPTR` sharing processors by ID (fewer than the `NPROC` processors in the system), together with a dirty flag and a broadcast flag. Read-miss and write requests arrive one at a time over a valid/ready handshake, each carrying the requester's processor ID and the entry address. The controller updates the entry in the cycle it accepts the request. It then issues the coherence commands that the request calls for on a separate valid/ready command stream.

Two commands exist. An invalidation goes either to one processor or, with the broadcast flag set, to every processor in the system. A write-back request asks the owner of a dirty block to return it. The parameter `BCAST_MODE` chooses what happens when a new reader finds every pointer slot taken. With `BCAST_MODE` = 1, the entry's broadcast flag is set and the reader is not recorded. With `BCAST_MODE` = 0, an existing sharer is invalidated and its slot is given to the reader. The victim slot is picked by a per-entry round-robin index.

Top module: `lpdir_ctrl`

## Requirements
- R1: After reset every entry is empty and clean with its broadcast flag clear and its round-robin index at slot 0; `req_ready` is 1 and `cmd_valid` is 0.
- R2: A read by a processor not yet recorded in a clean entry with a free slot records it in the lowest-numbered free slot and issues no command; `req_ready` stays 1.
- R3: A read by a processor already recorded in the entry changes nothing and issues no command; in particular it takes no second slot.
- R4: A write to an entry whose broadcast flag is clear issues one invalidation (`cmd_wb`=0, `cmd_bcast`=0, `cmd_target`=ID) for each other recorded sharer, in ascending slot order. Afterwards slot 0 holds the writer alone, the entry is dirty and its round-robin index returns to slot 0.
- R5: A read of a dirty entry by a processor other than the owner issues one write-back request (`cmd_wb`=1, `cmd_bcast`=0, `cmd_target`=owner). The entry then becomes clean and holds the owner in slot 0 and the reader in slot 1. A read of a dirty entry by its owner issues nothing.
- R6: With `BCAST_MODE`=1, a read by a new processor that finds all slots of a clean entry full sets the broadcast flag and issues no command. Further reads by new processors also issue nothing while the flag is set.
- R7: A write to an entry whose broadcast flag is set issues exactly one command with `cmd_bcast`=1, `cmd_wb`=0 and `cmd_target` = the writer, which is exempt. Afterwards the flag is clear and the writer is the sole, dirty holder.
- R8: With `BCAST_MODE`=0, a read by a new processor that finds all slots of a clean entry full issues one invalidation to the sharer in the slot named by the round-robin index. The reader is placed in that slot, and the index advances by one modulo `NPTR`.
- R9: While commands remain to be accepted, `req_ready` is 0, and a command offered with `cmd_ready` low is held unchanged until it is taken; one command is accepted per cycle at most.
- R10: Entries at different addresses are independent; every command carries the address of the request that caused it in `cmd_addr`.
- R11: A write never issues a single-target invalidation to the writer itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read miss |
| req_id | input | clog2(NPROC) | Requesting processor ID |
| req_addr | input | clog2(NENT) | Directory entry address |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command taken by the network |
| cmd_wb | output | 1 | 1 = write-back request, 0 = invalidation |
| cmd_bcast | output | 1 | 1 = invalidation to all processors |
| cmd_target | output | clog2(NPROC) | Target processor, or exempt writer on a broadcast |
| cmd_addr | output | clog2(NENT) | Entry address of the command |

## Verification
The bench builds two copies, each with eight processors, two pointer slots and four entries: `u0` with `BCAST_MODE`=1 and `u1` with `BCAST_MODE`=0. With only two slots, the third distinct reader already reaches overflow. In `u1` this lets the round-robin victim choice be followed through a wrap, through a reset of the index after a write, and through a slot reused after a duplicate read would otherwise have taken it. In `u0` it lets the broadcast flag be set and cleared in a few requests. Throttling `cmd_ready` on multi-command writes exposes the busy interval and the holding of offered commands.

// File: rtl/lpdir_pkg.sv
package lpdir_pkg;

   typedef enum logic {
      CMD_INV = 1'b0,
      CMD_WB  = 1'b1
   } cmd_kind_e;

endpackage

// File: rtl/lpdir_store.sv
module lpdir_store #(
   parameter int NPTR = 2,
   parameter int IDW  = 3,
   parameter int NENT = 4,
   parameter int AW   = 2,
   parameter int RRW  = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [AW-1:0]       rd_addr,
   output logic [NPTR-1:0]     rd_vld,
   output logic [NPTR*IDW-1:0] rd_ids,
   output logic                rd_dirty,
   output logic                rd_bcast,
   output logic [RRW-1:0]      rd_rr,
   input  logic                we,
   input  logic [AW-1:0]       wr_addr,
   input  logic [NPTR-1:0]     wr_vld,
   input  logic [NPTR*IDW-1:0] wr_ids,
   input  logic                wr_dirty,
   input  logic                wr_bcast,
   input  logic [RRW-1:0]      wr_rr
);

   logic [NPTR-1:0]     vld_q   [NENT];
   logic [NPTR*IDW-1:0] ids_q   [NENT];
   logic                dirty_q [NENT];
   logic                bcast_q [NENT];
   logic [RRW-1:0]      rr_q    [NENT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < NENT; e++) begin
            vld_q[e]   <= '0;
            ids_q[e]   <= '0;
            dirty_q[e] <= 1'b0;
            bcast_q[e] <= 1'b0;
            rr_q[e]    <= '0;
         end
      end else if (we) begin
         for (int e = 0; e < NENT; e++) begin
            if (wr_addr == AW'(e)) begin
               vld_q[e]   <= wr_vld;
               ids_q[e]   <= wr_ids;
               dirty_q[e] <= wr_dirty;
               bcast_q[e] <= wr_bcast;
               rr_q[e]    <= wr_rr;
            end
         end
      end
   end

   always_comb begin
      rd_vld   = '0;
      rd_ids   = '0;
      rd_dirty = 1'b0;
      rd_bcast = 1'b0;
      rd_rr    = '0;
      for (int e = 0; e < NENT; e++) begin
         if (rd_addr == AW'(e)) begin
            rd_vld   = vld_q[e];
            rd_ids   = ids_q[e];
            rd_dirty = dirty_q[e];
            rd_bcast = bcast_q[e];
            rd_rr    = rr_q[e];
         end
      end
   end

endmodule

// File: rtl/lpdir_plan.sv
module lpdir_plan
   import lpdir_pkg::*;
#(
   parameter int NPTR       = 2,
   parameter int IDW        = 3,
   parameter int RRW        = 1,
   parameter bit BCAST_MODE = 1'b1
) (
   input  logic                is_write,
   input  logic [IDW-1:0]      rid,
   input  logic [NPTR-1:0]     cur_vld,
   input  logic [NPTR*IDW-1:0] cur_ids,
   input  logic                cur_dirty,
   input  logic                cur_bcast,
   input  logic [RRW-1:0]      cur_rr,
   output logic [NPTR-1:0]     nxt_vld,
   output logic [NPTR*IDW-1:0] nxt_ids,
   output logic                nxt_dirty,
   output logic                nxt_bcast,
   output logic [RRW-1:0]      nxt_rr,
   output logic [NPTR-1:0]     plan_mask,
   output logic                plan_spec,
   output cmd_kind_e           plan_spec_kind,
   output logic                plan_spec_bc,
   output logic [IDW-1:0]      plan_spec_tgt
);

   localparam logic [RRW-1:0] RR_LAST = RRW'(NPTR - 1);

   // overflow outcome, one variant per policy
   logic [NPTR-1:0]     ovf_vld;
   logic [NPTR*IDW-1:0] ovf_ids;
   logic                ovf_bcast;
   logic [RRW-1:0]      ovf_rr;
   logic [NPTR-1:0]     ovf_mask;

   generate
      if (BCAST_MODE) begin : g_bcast
         always_comb begin
            ovf_vld   = cur_vld;
            ovf_ids   = cur_ids;
            ovf_bcast = 1'b1;
            ovf_rr    = cur_rr;
            ovf_mask  = '0;
         end
      end else begin : g_evict
         always_comb begin
            ovf_vld   = cur_vld;
            ovf_ids   = cur_ids;
            ovf_bcast = 1'b0;
            ovf_mask  = '0;
            for (int k = 0; k < NPTR; k++) begin
               if (cur_rr == RRW'(k)) begin
                  ovf_mask[k]            = 1'b1;
                  ovf_ids[k*IDW +: IDW]  = rid;
               end
            end
            ovf_rr = (cur_rr == RR_LAST) ? '0 : cur_rr + 1'b1;
         end
      end
   endgenerate

   logic [NPTR-1:0] hit;
   logic            free_any;
   logic [RRW-1:0]  free_idx;

   always_comb begin
      hit = '0;
      for (int k = 0; k < NPTR; k++) begin
         hit[k] = cur_vld[k] && (cur_ids[k*IDW +: IDW] == rid);
      end
      free_any = 1'b0;
      free_idx = '0;
      for (int k = NPTR - 1; k >= 0; k--) begin
         if (!cur_vld[k]) begin
            free_any = 1'b1;
            free_idx = RRW'(k);
         end
      end
   end

   always_comb begin
      nxt_vld        = cur_vld;
      nxt_ids        = cur_ids;
      nxt_dirty      = cur_dirty;
      nxt_bcast      = cur_bcast;
      nxt_rr         = cur_rr;
      plan_mask      = '0;
      plan_spec      = 1'b0;
      plan_spec_kind = CMD_INV;
      plan_spec_bc   = 1'b0;
      plan_spec_tgt  = rid;
      if (is_write) begin
         if (cur_bcast) begin
            plan_spec    = 1'b1;
            plan_spec_bc = 1'b1;
         end else begin
            plan_mask = cur_vld & ~hit;
         end
         nxt_vld            = '0;
         nxt_vld[0]         = 1'b1;
         nxt_ids            = '0;
         nxt_ids[IDW-1:0]   = rid;
         nxt_dirty          = 1'b1;
         nxt_bcast          = 1'b0;
         nxt_rr             = '0;
      end else if (cur_dirty) begin
         if (!hit[0]) begin
            plan_spec          = 1'b1;
            plan_spec_kind     = CMD_WB;
            plan_spec_tgt      = cur_ids[IDW-1:0];
            nxt_vld            = '0;
            nxt_vld[1:0]       = 2'b11;
            nxt_ids            = '0;
            nxt_ids[IDW-1:0]   = cur_ids[IDW-1:0];
            nxt_ids[IDW +: IDW] = rid;
            nxt_dirty          = 1'b0;
         end
      end else if (!(|hit) && !cur_bcast) begin
         if (free_any) begin
            nxt_vld[free_idx]                  = 1'b1;
            nxt_ids[int'(free_idx)*IDW +: IDW] = rid;
         end else begin
            nxt_vld   = ovf_vld;
            nxt_ids   = ovf_ids;
            nxt_bcast = ovf_bcast;
            nxt_rr    = ovf_rr;
            plan_mask = ovf_mask;
         end
      end
   end

endmodule

// File: rtl/lpdir_cmdseq.sv
module lpdir_cmdseq
   import lpdir_pkg::*;
#(
   parameter int NPTR = 2,
   parameter int IDW  = 3,
   parameter int AW   = 2,
   parameter int RRW  = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [NPTR-1:0]     ld_mask,
   input  logic [NPTR*IDW-1:0] ld_ids,
   input  logic                ld_spec,
   input  cmd_kind_e           ld_spec_kind,
   input  logic                ld_spec_bc,
   input  logic [IDW-1:0]      ld_spec_tgt,
   input  logic [AW-1:0]       ld_addr,
   output logic                busy,
   output logic                cmd_valid,
   input  logic                cmd_ready,
   output logic                cmd_wb,
   output logic                cmd_bcast,
   output logic [IDW-1:0]      cmd_target,
   output logic [AW-1:0]       cmd_addr
);

   logic [NPTR-1:0]     pend_q;
   logic [NPTR*IDW-1:0] ids_q;
   logic                spec_q;
   cmd_kind_e           kind_q;
   logic                bc_q;
   logic [IDW-1:0]      tgt_q;
   logic [AW-1:0]       addr_q;

   logic            have_slot;
   logic [RRW-1:0]  sel;
   logic            fire;

   always_comb begin
      have_slot = |pend_q;
      sel       = '0;
      for (int k = NPTR - 1; k >= 0; k--) begin
         if (pend_q[k]) sel = RRW'(k);
      end
   end

   assign busy      = have_slot | spec_q;
   assign cmd_valid = busy;
   assign fire      = cmd_valid && cmd_ready;
   assign cmd_addr  = addr_q;

   always_comb begin
      if (have_slot) begin
         cmd_wb     = 1'b0;
         cmd_bcast  = 1'b0;
         cmd_target = ids_q[int'(sel)*IDW +: IDW];
      end else begin
         cmd_wb     = (kind_q == CMD_WB);
         cmd_bcast  = bc_q;
         cmd_target = tgt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         ids_q  <= '0;
         spec_q <= 1'b0;
         kind_q <= CMD_INV;
         bc_q   <= 1'b0;
         tgt_q  <= '0;
         addr_q <= '0;
      end else if (load) begin
         pend_q <= ld_mask;
         ids_q  <= ld_ids;
         spec_q <= ld_spec;
         kind_q <= ld_spec_kind;
         bc_q   <= ld_spec_bc;
         tgt_q  <= ld_spec_tgt;
         addr_q <= ld_addr;
      end else if (fire) begin
         if (have_slot) pend_q[sel] <= 1'b0;
         else           spec_q      <= 1'b0;
      end
   end

endmodule

// File: rtl/lpdir_ctrl.sv
module lpdir_ctrl
   import lpdir_pkg::*;
#(
   parameter int NPROC      = 8,
   parameter int NPTR       = 2,
   parameter int NENT       = 4,
   parameter bit BCAST_MODE = 1'b1,
   localparam int IDW       = (NPROC > 1) ? $clog2(NPROC) : 1,
   localparam int AW        = (NENT > 1) ? $clog2(NENT) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic           req_write,
   input  logic [IDW-1:0] req_id,
   input  logic [AW-1:0]  req_addr,
   output logic           cmd_valid,
   input  logic           cmd_ready,
   output logic           cmd_wb,
   output logic           cmd_bcast,
   output logic [IDW-1:0] cmd_target,
   output logic [AW-1:0]  cmd_addr
);

   localparam int RRW = (NPTR > 1) ? $clog2(NPTR) : 1;

   generate
      if (NPTR < 2) begin : g_chk_nptr_lo
         $error("lpdir_ctrl: NPTR must be at least 2");
      end
      if (NPTR >= NPROC) begin : g_chk_nptr_hi
         $error("lpdir_ctrl: NPTR must be below NPROC");
      end
      if (NENT < 1) begin : g_chk_nent
         $error("lpdir_ctrl: NENT must be at least 1");
      end
   endgenerate

   logic [NPTR-1:0]     cur_vld, nxt_vld, plan_mask;
   logic [NPTR*IDW-1:0] cur_ids, nxt_ids;
   logic                cur_dirty, cur_bcast, nxt_dirty, nxt_bcast;
   logic [RRW-1:0]      cur_rr, nxt_rr;
   logic                plan_spec, plan_spec_bc;
   cmd_kind_e           plan_spec_kind;
   logic [IDW-1:0]      plan_spec_tgt;
   logic                busy, accept;

   assign req_ready = !busy;
   assign accept    = req_valid && !busy;

   lpdir_store #(
      .NPTR(NPTR), .IDW(IDW), .NENT(NENT), .AW(AW), .RRW(RRW)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_addr  (req_addr),
      .rd_vld   (cur_vld),
      .rd_ids   (cur_ids),
      .rd_dirty (cur_dirty),
      .rd_bcast (cur_bcast),
      .rd_rr    (cur_rr),
      .we       (accept),
      .wr_addr  (req_addr),
      .wr_vld   (nxt_vld),
      .wr_ids   (nxt_ids),
      .wr_dirty (nxt_dirty),
      .wr_bcast (nxt_bcast),
      .wr_rr    (nxt_rr)
   );

   lpdir_plan #(
      .NPTR(NPTR), .IDW(IDW), .RRW(RRW), .BCAST_MODE(BCAST_MODE)
   ) u_plan (
      .is_write       (req_write),
      .rid            (req_id),
      .cur_vld        (cur_vld),
      .cur_ids        (cur_ids),
      .cur_dirty      (cur_dirty),
      .cur_bcast      (cur_bcast),
      .cur_rr         (cur_rr),
      .nxt_vld        (nxt_vld),
      .nxt_ids        (nxt_ids),
      .nxt_dirty      (nxt_dirty),
      .nxt_bcast      (nxt_bcast),
      .nxt_rr         (nxt_rr),
      .plan_mask      (plan_mask),
      .plan_spec      (plan_spec),
      .plan_spec_kind (plan_spec_kind),
      .plan_spec_bc   (plan_spec_bc),
      .plan_spec_tgt  (plan_spec_tgt)
   );

   lpdir_cmdseq #(
      .NPTR(NPTR), .IDW(IDW), .AW(AW), .RRW(RRW)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (accept),
      .ld_mask      (plan_mask),
      .ld_ids       (cur_ids),
      .ld_spec      (plan_spec),
      .ld_spec_kind (plan_spec_kind),
      .ld_spec_bc   (plan_spec_bc),
      .ld_spec_tgt  (plan_spec_tgt),
      .ld_addr      (req_addr),
      .busy         (busy),
      .cmd_valid    (cmd_valid),
      .cmd_ready    (cmd_ready),
      .cmd_wb       (cmd_wb),
      .cmd_bcast    (cmd_bcast),
      .cmd_target   (cmd_target),
      .cmd_addr     (cmd_addr)
   );

endmodule

// File: rtl/lpdir_ctrl_chk.sv
module lpdir_ctrl_chk #(
   parameter int NPROC      = 8,
   parameter int NENT       = 4,
   parameter bit BCAST_MODE = 1'b1,
   localparam int IDW       = (NPROC > 1) ? $clog2(NPROC) : 1,
   localparam int AW        = (NENT > 1) ? $clog2(NENT) : 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req_valid,
   input logic           req_ready,
   input logic           req_write,
   input logic [IDW-1:0] req_id,
   input logic           cmd_valid,
   input logic           cmd_ready,
   input logic           cmd_wb,
   input logic           cmd_bcast,
   input logic [IDW-1:0] cmd_target,
   input logic [AW-1:0]  cmd_addr
);

   logic           last_wr_q;
   logic [IDW-1:0] last_id_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_wr_q <= 1'b0;
         last_id_q <= '0;
      end else if (req_valid && req_ready) begin
         last_wr_q <= req_write;
         last_id_q <= req_id;
      end
   end

   // R9: no request is taken while commands are outstanding
   a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !req_ready);

   // R9: an offered command holds still under backpressure
   a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_wb) && $stable(cmd_bcast)
                                     && $stable(cmd_target) && $stable(cmd_addr)));

   // R11: a writer never receives its own single-target invalidation
   a_r11_no_self_inv: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && last_wr_q && !cmd_bcast) |-> (cmd_target != last_id_q));

   // R7: broadcasts only follow writes and are never write-backs
   a_r7_bcast_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_bcast) |-> (last_wr_q && !cmd_wb));

   // R5: write-back requests only follow reads
   a_r5_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_wb) |-> !last_wr_q);

   // R8: the eviction policy never broadcasts
   a_r8_evict_no_bcast: assert property (@(posedge clk) disable iff (!rst_n)
      (!BCAST_MODE && cmd_valid) |-> !cmd_bcast);

endmodule

bind lpdir_ctrl lpdir_ctrl_chk #(
   .NPROC(NPROC), .NENT(NENT), .BCAST_MODE(BCAST_MODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_write  (req_write),
   .req_id     (req_id),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .cmd_wb     (cmd_wb),
   .cmd_bcast  (cmd_bcast),
   .cmd_target (cmd_target),
   .cmd_addr   (cmd_addr)
);

// File: tb/sim_lpdir_ctrl.sv
`timescale 1ns/1ps
module sim_lpdir_ctrl;

   typedef struct {
      logic [6:0] v;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [1:0] req_valid, req_write, req_ready;
   logic [1:0] cmd_valid, cmd_ready, cmd_wb, cmd_bcast;
   logic [2:0] req_id [2];
   logic [2:0] cmd_target [2];
   logic [1:0] req_addr [2];
   logic [1:0] cmd_addr [2];

   logic [3:0] rc = 4'd0;
   bit stall = 1'b0;
   always @(posedge clk) rc <= rc + 4'd1;
   assign cmd_ready[0] = stall ? (rc[1:0] == 2'b11) : 1'b1;
   assign cmd_ready[1] = stall ? (rc[1:0] == 2'b01) : 1'b1;

   lpdir_ctrl #(.NPROC(8), .NPTR(2), .NENT(4), .BCAST_MODE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_write(req_write[0]),
      .req_id(req_id[0]), .req_addr(req_addr[0]),
      .cmd_valid(cmd_valid[0]), .cmd_ready(cmd_ready[0]), .cmd_wb(cmd_wb[0]),
      .cmd_bcast(cmd_bcast[0]), .cmd_target(cmd_target[0]), .cmd_addr(cmd_addr[0]));

   lpdir_ctrl #(.NPROC(8), .NPTR(2), .NENT(4), .BCAST_MODE(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_write(req_write[1]),
      .req_id(req_id[1]), .req_addr(req_addr[1]),
      .cmd_valid(cmd_valid[1]), .cmd_ready(cmd_ready[1]), .cmd_wb(cmd_wb[1]),
      .cmd_bcast(cmd_bcast[1]), .cmd_target(cmd_target[1]), .cmd_addr(cmd_addr[1]));

   int checks = 0;
   int failures = 0;
   exp_t q0[$];
   exp_t q1[$];

   task automatic chk(bit ok, string tag, string what, int act, int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   // driver side: expected command {wb, bcast, target, addr}
   task automatic push(int d, bit wb, bit bc, logic [2:0] tgt, logic [1:0] a, string tag);
      exp_t e;
      e.v = {wb, bc, tgt, a};
      e.tag = tag;
      if (d == 0) q0.push_back(e); else q1.push_back(e);
   endtask

   // monitor side
   task automatic mon(int d);
      exp_t e;
      logic [6:0] got;
      got = {cmd_wb[d], cmd_bcast[d], cmd_target[d], cmd_addr[d]};
      if ((d == 0 && q0.size() == 0) || (d == 1 && q1.size() == 0)) begin
         chk(1'b0, "R10", $sformatf("u%0d unexpected command", d), int'(got), 0);
      end else begin
         e = (d == 0) ? q0.pop_front() : q1.pop_front();
         chk(got == e.v, e.tag, $sformatf("u%0d command {wb,bc,tgt,addr}", d),
             int'(got), int'(e.v));
      end
   endtask

   always @(negedge clk) if (rst_n && cmd_valid[0] && cmd_ready[0]) mon(0);
   always @(negedge clk) if (rst_n && cmd_valid[1] && cmd_ready[1]) mon(1);

   task automatic do_req(int d, bit wr, logic [2:0] id, logic [1:0] a);
      @(negedge clk);
      req_valid[d] = 1'b1;
      req_write[d] = wr;
      req_id[d]    = id;
      req_addr[d]  = a;
      @(posedge clk);
      #1 req_valid[d] = 1'b0;
   endtask

   task automatic wait_idle(int d, string tag);
      do @(negedge clk); while (!(req_ready[d] && !cmd_valid[d]));
      chk(((d == 0) ? q0.size() : q1.size()) == 0, tag,
          $sformatf("u%0d expected commands left", d),
          (d == 0) ? q0.size() : q1.size(), 0);
   endtask

   task automatic req(int d, bit wr, logic [2:0] id, logic [1:0] a, string tag);
      do_req(d, wr, id, a);
      wait_idle(d, tag);
   endtask

   task automatic req_busy(int d, bit wr, logic [2:0] id, logic [1:0] a, string tag);
      do_req(d, wr, id, a);
      @(negedge clk);
      chk(req_ready[d] == 1'b0, "R9", $sformatf("u%0d req_ready while busy", d),
          int'(req_ready[d]), 0);
      chk(cmd_valid[d] == 1'b1, "R9", $sformatf("u%0d cmd_valid while busy", d),
          int'(cmd_valid[d]), 1);
      wait_idle(d, tag);
   endtask

   task automatic run_all();
      // R1: reset state
      for (int d = 0; d < 2; d++) begin
         chk(req_ready[d] == 1'b1, "R1", "req_ready after reset", int'(req_ready[d]), 1);
         chk(cmd_valid[d] == 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid[d]), 0);
      end

      // ---------- u1: eviction policy ----------
      req(1, 0, 3'd1, 2'd0, "R2");
      req(1, 0, 3'd1, 2'd0, "R3");
      req(1, 0, 3'd2, 2'd0, "R3");   // takes slot 1 only if R3 held
      push(1, 0, 0, 3'd1, 2'd0, "R8"); req(1, 0, 3'd3, 2'd0, "R8");
      push(1, 0, 0, 3'd2, 2'd0, "R8"); req(1, 0, 3'd4, 2'd0, "R8");
      stall = 1'b1;
      push(1, 0, 0, 3'd3, 2'd0, "R8"); req(1, 0, 3'd5, 2'd0, "R8");  // wrapped index
      push(1, 0, 0, 3'd5, 2'd0, "R11"); req_busy(1, 1, 3'd4, 2'd0, "R11");
      push(1, 1, 0, 3'd4, 2'd0, "R5"); req(1, 0, 3'd6, 2'd0, "R5");
      push(1, 0, 0, 3'd4, 2'd0, "R4"); push(1, 0, 0, 3'd6, 2'd0, "R4");
      req_busy(1, 1, 3'd7, 2'd0, "R4");
      stall = 1'b0;
      req(1, 0, 3'd0, 2'd1, "R10");
      push(1, 0, 0, 3'd0, 2'd1, "R10"); req(1, 1, 3'd2, 2'd1, "R10");
      push(1, 0, 0, 3'd7, 2'd0, "R10"); req(1, 1, 3'd1, 2'd0, "R10");
      push(1, 1, 0, 3'd1, 2'd0, "R5"); req(1, 0, 3'd3, 2'd0, "R5");
      push(1, 0, 0, 3'd1, 2'd0, "R8"); req(1, 0, 3'd5, 2'd0, "R8");  // index reset by write
      push(1, 0, 0, 3'd3, 2'd0, "R8"); req(1, 0, 3'd6, 2'd0, "R8");

      // ---------- u0: broadcast policy ----------
      req(0, 0, 3'd1, 2'd0, "R2");
      req(0, 0, 3'd2, 2'd0, "R2");
      req(0, 0, 3'd3, 2'd0, "R6");
      req(0, 0, 3'd4, 2'd0, "R6");
      stall = 1'b1;
      push(0, 0, 1, 3'd2, 2'd0, "R7"); req_busy(0, 1, 3'd2, 2'd0, "R7");
      push(0, 1, 0, 3'd2, 2'd0, "R7"); req(0, 0, 3'd5, 2'd0, "R7");
      push(0, 0, 0, 3'd2, 2'd0, "R7"); req(0, 1, 3'd5, 2'd0, "R7");
      stall = 1'b0;
      req(0, 0, 3'd5, 2'd0, "R5");   // owner read: nothing
      req(0, 0, 3'd0, 2'd3, "R10");
      req(0, 0, 3'd1, 2'd3, "R10");
      req(0, 0, 3'd2, 2'd3, "R6");
      push(0, 0, 1, 3'd6, 2'd3, "R10"); req(0, 1, 3'd6, 2'd3, "R10");
   endtask

   initial begin
      req_valid = '0;
      req_write = '0;
      for (int d = 0; d < 2; d++) begin
         req_id[d] = '0;
         req_addr[d] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            chk(1'b0, "R9", "watchdog expired", 0, 1);
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule